// File: doc/BRIEF.md
# Parallel-Port Timer and Interrupt Register File

This block is a byte-wide register file with sixteen slots. It sits behind a simple read/write strobe bus and is selected by a 4-bit slot number. It stores two parallel-port data bytes, their direction masks, a shift-data byte, an auxiliary control byte, a peripheral control byte and a second copy of the port-A byte that is accessed without handshake. It also holds two 16-bit down-counters and the reload latch of the first counter. A set of seven interrupt flags, with a matching enable mask, drives one interrupt line.

Both counters move down by one on each cycle in which the prescaler input `tick` is high. When auxiliary control bits [7:6] are 01, timer 1 runs in continuous mode. In that mode it reloads from its latch when it underflows and raises its flag in the same cycle. In any other mode it wraps silently. Another block owns the shift-data path and feeds its flag in as a single-cycle pulse.

Top module: `pio_timer_regs`

## Requirements
- R1: After reset, both counters and the timer-1 latch hold 0xFFFF, the flag and enable registers read 0x00, and `irq` is low.
- R2: Slots 0 (port B), 1 (port A), 2 (port B direction), 3 (port A direction), 10 (shift data), 11 (auxiliary control), 12 (peripheral control) and 15 (port A, no handshake) read back the last byte written to them.
- R3: Writing counter slot 4 or 8 replaces only the low byte, and writing slot 5 or 9 replaces only the high byte. The other byte keeps its present count. A write overrides any tick in the same cycle.
- R4: Each counter decrements by one per cycle with `tick` high. It holds when `tick` is low, and outside continuous mode timer 1 goes from 0x0000 to 0xFFFF.
- R5: With auxiliary control bits [7:6] = 01, a tick at count 0 loads timer 1 from its latch and sets flag bit 6 in the same cycle. The period is therefore latch+1 ticks.
- R6: When auxiliary control bits [7:6] are not 01, a timer-1 underflow leaves flag bit 6 unchanged.
- R7: A read strobe on slot 4 or slot 5 clears flag bit 6.
- R8: A write to slot 13 clears every flag bit whose data bit is 1 and leaves the others.
- R9: A write to slot 14 with data bit 7 = 1 sets the enable bits written as 1 in [6:0]. With bit 7 = 0 it clears them. Slot 14 reads the mask with bit 7 = 0.
- R10: `irq` is high exactly when some flag bit [6:0] and its enable bit are both set, and slot 13 reads that same condition in bit 7 above the flags in [6:0].
- R11: A `sr_flag` pulse sets flag bit 2. When a set and a clear of the same flag coincide, the set wins.
- R12: Slots 6 and 7 write and read the latch low and high bytes independently, with no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler enable; one counter decrement per high cycle |
| reg_idx | input | 4 | Slot number for read and write |
| wr_en | input | 1 | Write strobe, applied at the clock edge |
| rd_en | input | 1 | Read strobe; triggers read side effects at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `reg_idx` |
| sr_flag | input | 1 | Shift-data completion pulse |
| irq | output | 1 | Interrupt request |

## Verification
A counter that is off by one shows up as a wrong byte on the next read of slot 4, 5, 8 or 9. It also moves the instant at which flag bit 6 appears, by one tick, so the bench samples slot 13 one tick before and at the expected underflow. A flag or enable bit stuck high or low reaches `irq` and slot 13 bit 7 in the same cycle as the register edge. A clear that fires on the wrong strobe is visible on the very next read of slot 13.

// File: rtl/pio_timer_regs.sv
module pio_timer_regs #(
  parameter int DW = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [IW-1:0] reg_idx,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          sr_flag,
  output logic          irq
);
  localparam int TW = 2 * DW;
  localparam int FW = DW - 1;
  localparam int BIT_T1 = 6;
  localparam int BIT_SR = 2;
  localparam logic [TW-1:0] ONE = 1;

  localparam logic [IW-1:0] IX_PB   = 0;
  localparam logic [IW-1:0] IX_PA   = 1;
  localparam logic [IW-1:0] IX_DB   = 2;
  localparam logic [IW-1:0] IX_DA   = 3;
  localparam logic [IW-1:0] IX_T1L  = 4;
  localparam logic [IW-1:0] IX_T1H  = 5;
  localparam logic [IW-1:0] IX_LTL  = 6;
  localparam logic [IW-1:0] IX_LTH  = 7;
  localparam logic [IW-1:0] IX_T2L  = 8;
  localparam logic [IW-1:0] IX_T2H  = 9;
  localparam logic [IW-1:0] IX_SHR  = 10;
  localparam logic [IW-1:0] IX_AUX  = 11;
  localparam logic [IW-1:0] IX_PER  = 12;
  localparam logic [IW-1:0] IX_FLG  = 13;
  localparam logic [IW-1:0] IX_ENA  = 14;
  localparam logic [IW-1:0] IX_PANH = 15;

  logic [DW-1:0] pb, pa, db, da, shr, aux, per, pa_nh;
  logic [TW-1:0] t1_cnt, t1_lat, t2_cnt;
  logic [FW-1:0] flg, ena, flg_set, flg_clr;

  wire wr_hit_t1l = wr_en && reg_idx == IX_T1L;
  wire wr_hit_t1h = wr_en && reg_idx == IX_T1H;
  wire wr_hit_t2l = wr_en && reg_idx == IX_T2L;
  wire wr_hit_t2h = wr_en && reg_idx == IX_T2H;
  wire t1_cont    = aux[7:6] == 2'b01;
  wire t1_evt     = tick && t1_cnt == '0 && t1_cont && !wr_hit_t1l && !wr_hit_t1h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb <= '0; pa <= '0; db <= '0; da <= '0;
      shr <= '0; aux <= '0; per <= '0; pa_nh <= '0;
      t1_lat <= '1;
    end else if (wr_en) begin
      case (reg_idx)
        IX_PB:   pb <= wdata;
        IX_PA:   pa <= wdata;
        IX_DB:   db <= wdata;
        IX_DA:   da <= wdata;
        IX_LTL:  t1_lat <= {t1_lat[TW-1:DW], wdata};
        IX_LTH:  t1_lat <= {wdata, t1_lat[DW-1:0]};
        IX_SHR:  shr <= wdata;
        IX_AUX:  aux <= wdata;
        IX_PER:  per <= wdata;
        IX_PANH: pa_nh <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          t1_cnt <= '1;
    else if (wr_hit_t1l) t1_cnt <= {t1_cnt[TW-1:DW], wdata};
    else if (wr_hit_t1h) t1_cnt <= {wdata, t1_cnt[DW-1:0]};
    else if (t1_evt)     t1_cnt <= t1_lat;
    else if (tick)       t1_cnt <= t1_cnt - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          t2_cnt <= '1;
    else if (wr_hit_t2l) t2_cnt <= {t2_cnt[TW-1:DW], wdata};
    else if (wr_hit_t2h) t2_cnt <= {wdata, t2_cnt[DW-1:0]};
    else if (tick)       t2_cnt <= t2_cnt - ONE;
  end

  always_comb begin
    flg_set = '0;
    flg_set[BIT_T1] = t1_evt;
    flg_set[BIT_SR] = sr_flag;
    flg_clr = '0;
    if (wr_en && reg_idx == IX_FLG) flg_clr = wdata[FW-1:0];
    if (rd_en && (reg_idx == IX_T1L || reg_idx == IX_T1H)) flg_clr[BIT_T1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg <= '0;
      ena <= '0;
    end else begin
      flg <= (flg & ~flg_clr) | flg_set;
      if (wr_en && reg_idx == IX_ENA)
        ena <= wdata[DW-1] ? (ena | wdata[FW-1:0]) : (ena & ~wdata[FW-1:0]);
    end
  end

  assign irq = |(flg & ena);

  always_comb begin
    case (reg_idx)
      IX_PB:   rdata = pb;
      IX_PA:   rdata = pa;
      IX_DB:   rdata = db;
      IX_DA:   rdata = da;
      IX_T1L:  rdata = t1_cnt[DW-1:0];
      IX_T1H:  rdata = t1_cnt[TW-1:DW];
      IX_LTL:  rdata = t1_lat[DW-1:0];
      IX_LTH:  rdata = t1_lat[TW-1:DW];
      IX_T2L:  rdata = t2_cnt[DW-1:0];
      IX_T2H:  rdata = t2_cnt[TW-1:DW];
      IX_SHR:  rdata = shr;
      IX_AUX:  rdata = aux;
      IX_PER:  rdata = per;
      IX_FLG:  rdata = {irq, flg};
      IX_ENA:  rdata = {1'b0, ena};
      default: rdata = pa_nh;
    endcase
  end

  AST_T1_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_cont && tick && t1_cnt == '0 && !wr_hit_t1l && !wr_hit_t1h) |=> (t1_cnt == $past(t1_lat) && flg[BIT_T1])); // R5
  AST_NO_T1_FLAG_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !t1_cont |=> !$rose(flg[BIT_T1])); // R6
  AST_RD_CLEARS_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (reg_idx == IX_T1L || reg_idx == IX_T1H) && !t1_evt) |=> !flg[BIT_T1]); // R7
  AST_W1C_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IX_FLG && !sr_flag && !t1_evt) |=> ((flg & $past(wdata[FW-1:0])) == '0)); // R8
  AST_ENA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IX_ENA && wdata[DW-1]) |=> ((ena & $past(wdata[FW-1:0])) == $past(wdata[FW-1:0]))); // R9
  AST_CNT_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_t1l |=> (t1_cnt[DW-1:0] == $past(wdata) && t1_cnt[TW-1:DW] == $past(t1_cnt[TW-1:DW]))); // R3
  AST_SR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    sr_flag |=> flg[BIT_SR]); // R11
endmodule

// File: tb/test_pio_timer_regs.sv
`timescale 1ns/1ps
module test_pio_timer_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] reg_idx = '0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic sr_flag = 1'b0;
  logic irq;
  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pio_timer_regs i_pio_timer_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_idx(reg_idx),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .sr_flag(sr_flag), .irq(irq)
  );

  // {slot, data written, data expected back}
  localparam logic [19:0] VEC [10] = '{
    {4'd0,  8'h5A, 8'h5A}, {4'd1,  8'hC3, 8'hC3}, {4'd2,  8'h0F, 8'h0F},
    {4'd3,  8'hF0, 8'hF0}, {4'd10, 8'h99, 8'h99}, {4'd11, 8'hA5, 8'hA5},
    {4'd12, 8'h3C, 8'h3C}, {4'd15, 8'h7E, 8'h7E}, {4'd6,  8'h11, 8'h11},
    {4'd7,  8'h22, 8'h22}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk); reg_idx = idx; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] v);
    @(negedge clk); reg_idx = idx; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] idx, output logic [7:0] v);
    @(negedge clk); reg_idx = idx; #1 v = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(4'd4, v);  chk("R1 t1 lo", v, 8'hFF);
    peek(4'd5, v);  chk("R1 t1 hi", v, 8'hFF);
    peek(4'd6, v);  chk("R1 latch lo", v, 8'hFF);
    peek(4'd7, v);  chk("R1 latch hi", v, 8'hFF);
    peek(4'd9, v);  chk("R1 t2 hi", v, 8'hFF);
    peek(4'd13, v); chk("R1 flags", v, 8'h00);
    peek(4'd14, v); chk("R1 enables", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 and R12 table walk
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      peek(VEC[i][19:16], v);
      chk("R2/R12 table", v, VEC[i][7:0]);
    end
    peek(4'd4, v); chk("R12 counter untouched lo", v, 8'hFF);
    peek(4'd6, v); chk("R12 latch lo kept", v, 8'h11);

    // R3 byte writes
    wr(4'd4, 8'h34);
    peek(4'd5, v); chk("R3 hi kept", v, 8'hFF);
    wr(4'd5, 8'h12);
    peek(4'd4, v); chk("R3 lo kept", v, 8'h34);
    peek(4'd5, v); chk("R3 hi new", v, 8'h12);

    // R4 decrement and hold
    ticks(3);
    peek(4'd4, v); chk("R4 t1 after 3 ticks", v, 8'h31);
    repeat (4) @(negedge clk);
    peek(4'd4, v); chk("R4 hold without tick", v, 8'h31);
    wr(4'd8, 8'h10); wr(4'd9, 8'h00);
    ticks(5);
    peek(4'd8, v); chk("R4 t2 lo", v, 8'h0B);
    peek(4'd9, v); chk("R4 t2 hi", v, 8'h00);

    // R4/R6 wrap outside continuous mode
    wr(4'd11, 8'h00);
    wr(4'd4, 8'h01); wr(4'd5, 8'h00);
    ticks(2);
    peek(4'd4, v);  chk("R4 wrap lo", v, 8'hFF);
    peek(4'd5, v);  chk("R4 wrap hi", v, 8'hFF);
    peek(4'd13, v); chk("R6 no flag on wrap", v, 8'h00);

    // R5 continuous mode
    wr(4'd6, 8'h03); wr(4'd7, 8'h00);
    wr(4'd4, 8'h02); wr(4'd5, 8'h00);
    wr(4'd11, 8'h40);
    ticks(2);
    peek(4'd13, v); chk("R5 no flag before underflow", v, 8'h00);
    ticks(1);
    peek(4'd13, v); chk("R5 flag on underflow", v, 8'h40);
    rd(4'd4, v);    chk("R5 reload value", v, 8'h03);
    peek(4'd13, v); chk("R7 read lo clears", v, 8'h00);
    ticks(3);
    peek(4'd13, v); chk("R5 period tick 3", v, 8'h00);
    ticks(1);
    peek(4'd13, v); chk("R5 period tick 4", v, 8'h40);

    // R10 / R9 / R8
    wr(4'd14, 8'hC0);
    chk("R10 irq high", {7'd0, irq}, 8'h01);
    peek(4'd13, v); chk("R10 summary bit", v, 8'hC0);
    peek(4'd14, v); chk("R9 enable set", v, 8'h40);
    wr(4'd13, 8'h40);
    peek(4'd13, v); chk("R8 w1c", v, 8'h00);
    chk("R10 irq low", {7'd0, irq}, 8'h00);
    ticks(4);
    chk("R10 irq again", {7'd0, irq}, 8'h01);
    rd(4'd5, v);
    peek(4'd13, v); chk("R7 read hi clears", v, 8'h00);
    wr(4'd14, 8'h40);
    peek(4'd14, v); chk("R9 enable clear", v, 8'h00);

    // R6 leaving continuous mode stops flags
    wr(4'd11, 8'h00);
    ticks(8);
    peek(4'd13, v); chk("R6 no flag after leave", v, 8'h00);

    // R11 shift flag, set beats clear
    wr(4'd14, 8'h84);
    @(negedge clk); sr_flag = 1'b1;
    @(negedge clk); sr_flag = 1'b0;
    peek(4'd13, v); chk("R11 sr flag set", v, 8'h84);
    @(negedge clk); reg_idx = 4'd13; wdata = 8'h04; wr_en = 1'b1; sr_flag = 1'b1;
    @(negedge clk); wr_en = 1'b0; sr_flag = 1'b0;
    peek(4'd13, v); chk("R11 set wins", v, 8'h84);
    wr(4'd13, 8'h04);
    peek(4'd13, v); chk("R8 sr flag cleared", v, 8'h00);
    chk("R10 irq off", {7'd0, irq}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule